// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a watchdog peripheral that sits behind a simple register bus. Writes complete in a single cycle. Reads are combinational. A down counter runs two stages in turn. The first stage is loaded from one preload value and the second from another. When the first stage ends, a sticky timeout flag is set. When the second stage ends, a reset request is pulsed. That pulse is tagged warm or cold, and the block can also toggle a timeout pin.

The preload registers and the command register are protected. A write to any of them lands only if a two-byte key went to the key register directly beforehand. Software keeps the system alive by writing the key and then a refresh command, which restarts the first stage.

Once the lock bit is set, software can no longer turn the watchdog off. The lock bit also freezes the configuration byte. Only a system reset clears it.

Every write is a plain one-cycle strobe, with no handshake and no back-pressure. Byte registers take `wr_data[7:0]`. Each preload register takes the low `PRE_W` bits.

Top module: `wdt_keyed`

## Requirements
- R1: A write to a preload register (0x00, 0x04) or the command register (0x0D) takes effect only when the two writes immediately before it were 0x80 and then 0x86 to the key register at 0x0C.
- R2: One key sequence authorises a single protected write. A second protected write without a new key has no effect.
- R3: Any of the following cancels a key in progress, so a later protected write has no effect:
  - a byte to 0x0C other than the expected key byte;
  - any write to another address between or after the key bytes.
- R4: A keyed command write with bit 0 set restarts the first stage with its full length.
- R5: A keyed command write with bit 1 set clears the timeout flag. The flag reads back at 0x0C bit 9.
- R6: With prescaler select (configuration bit 2) clear, the first stage lasts P1+1 clocks, counted from the enabling write. The timeout flag then rises and the second stage starts.
- R7: With prescaler select set, each preload occupies the upper bits above FRAC count bits. The first stage then lasts (P1+1)·2^FRAC clocks.
- R8: The second stage lasts P2+1 clocks. At its end, if reset enable (configuration bit 4) is set, `rst_req` is high for exactly 4 clocks. `rst_warm` follows the warm-reset bit (configuration bit 3).
- R9: At the end of the second stage, `tout_pin` inverts unless toggle disable (configuration bit 5) is set.
- R10: Lock register 0x18 holds enable in bit 1 and lock in bit 0. Once the lock bit is set:
  - it stays set until `rst_n` is asserted;
  - enable cannot be cleared;
  - the configuration byte at 0x10 cannot be changed.
- R11: After reset all registers are zero and the outputs are low. While enable is clear, the counter (readable at 0x14) holds the first-stage load value and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| tout_flag | output | 1 | Sticky first-stage timeout flag |
| rst_req | output | 1 | Reset request pulse |
| rst_warm | output | 1 | 1 = warm reset requested, 0 = cold |
| tout_pin | output | 1 | Timeout pin, toggled at second-stage end |

## Verification
Each fault shows up at the ports. A key checker stuck in its armed state shows on the very next read of a preload register, which returns a value that should have been refused. A wrong count or stage shows as `tout_flag` or `rst_req` rising a measurable number of clocks early or late, so timing is measured in cycles from the enabling or refreshing write. A lost lock shows at once on reading back 0x18 or 0x10 after an attempted clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [4:0] A_PRE1 = 5'h00;
  localparam logic [4:0] A_PRE2 = 5'h04;
  localparam logic [4:0] A_KEY  = 5'h0C;
  localparam logic [4:0] A_CMD  = 5'h0D;
  localparam logic [4:0] A_CFG  = 5'h10;
  localparam logic [4:0] A_CNT  = 5'h14;
  localparam logic [4:0] A_LOCK = 5'h18;

  localparam logic [7:0] KEY_A = 8'h80;
  localparam logic [7:0] KEY_B = 8'h86;

  localparam int RST_PULSE = 4;

  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_st_t;
  typedef enum logic {ST_ONE, ST_TWO} stage_t;

  typedef struct packed {
    logic no_toggle;
    logic rst_en;
    logic warm;
    logic presc;
  } cfg_t;
endpackage

// File: rtl/wdt_key.sv
module wdt_key
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_addr,
  input  logic [7:0] wr_byte,
  output logic       grant,
  output logic       armed
);
  key_st_t st_q;
  logic    prot;

  assign prot  = (wr_addr == A_PRE1) || (wr_addr == A_PRE2) || (wr_addr == A_CMD);
  assign armed = (st_q == K_ARMED);
  assign grant = wr_en && armed && prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= K_IDLE;
    end else if (wr_en) begin
      if (wr_addr == A_KEY) begin
        if (wr_byte == KEY_A)
          st_q <= K_HALF;
        else if (wr_byte == KEY_B && st_q == K_HALF)
          st_q <= K_ARMED;
        else
          st_q <= K_IDLE;
      end else begin
        st_q <= K_IDLE;
      end
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int PRE_W = 20,
  parameter int FRAC  = 15,
  localparam int CNT_W = PRE_W + FRAC
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             kick,
  input  logic             presc,
  input  logic [PRE_W-1:0] pre1,
  input  logic [PRE_W-1:0] pre2,
  output logic             s1_exp,
  output logic             s2_exp,
  output logic [CNT_W-1:0] cnt
);
  stage_t stage_q;
  logic   at_zero;

  function automatic logic [CNT_W-1:0] load_val(input logic [PRE_W-1:0] p, input logic ps);
    if (ps) return {p, {FRAC{1'b1}}};
    else    return CNT_W'(p);
  endfunction

  assign at_zero = (cnt == '0);
  assign s1_exp  = en && !kick && at_zero && (stage_q == ST_ONE);
  assign s2_exp  = en && !kick && at_zero && (stage_q == ST_TWO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_ONE;
      cnt     <= '0;
    end else if (!en || kick) begin
      stage_q <= ST_ONE;
      cnt     <= load_val(pre1, presc);
    end else if (at_zero) begin
      if (stage_q == ST_ONE) begin
        stage_q <= ST_TWO;
        cnt     <= load_val(pre2, presc);
      end else begin
        stage_q <= ST_ONE;
        cnt     <= load_val(pre1, presc);
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int PRE_W = 20,
  parameter int FRAC  = 15,
  localparam int CNT_W = PRE_W + FRAC,
  localparam int RC_W  = $clog2(RST_PULSE + 1)
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        tout_flag,
  output logic        rst_req,
  output logic        rst_warm,
  output logic        tout_pin
);
  logic             grant, armed;
  logic [PRE_W-1:0] pre1_q, pre2_q;
  cfg_t             cfg_q;
  logic             en_q, lock_q;
  logic             kick, clr_flag;
  logic             s1_exp, s2_exp;
  logic [CNT_W-1:0] cnt;
  logic [RC_W-1:0]  rcnt_q;

  wdt_key u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_byte(wr_data[7:0]), .grant(grant), .armed(armed)
  );

  assign kick     = grant && (wr_addr == A_CMD) && wr_data[0];
  assign clr_flag = grant && (wr_addr == A_CMD) && wr_data[1];

  wdt_counter #(.PRE_W(PRE_W), .FRAC(FRAC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .kick(kick), .presc(cfg_q.presc),
    .pre1(pre1_q), .pre2(pre2_q), .s1_exp(s1_exp), .s2_exp(s2_exp), .cnt(cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre1_q <= '0;
      pre2_q <= '0;
      cfg_q  <= '0;
      en_q   <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr_en) begin
      if (grant && wr_addr == A_PRE1) pre1_q <= wr_data[PRE_W-1:0];
      if (grant && wr_addr == A_PRE2) pre2_q <= wr_data[PRE_W-1:0];
      if (wr_addr == A_CFG && !lock_q) cfg_q <= wr_data[5:2];
      if (wr_addr == A_LOCK) begin
        lock_q <= lock_q | wr_data[0];
        en_q   <= lock_q ? (en_q | wr_data[1]) : wr_data[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout_flag <= 1'b0;
      rcnt_q    <= '0;
      tout_pin  <= 1'b0;
    end else begin
      if (s1_exp)        tout_flag <= 1'b1;
      else if (clr_flag) tout_flag <= 1'b0;
      if (s2_exp && cfg_q.rst_en) rcnt_q <= RC_W'(RST_PULSE);
      else if (rcnt_q != '0)      rcnt_q <= rcnt_q - 1'b1;
      if (s2_exp && !cfg_q.no_toggle) tout_pin <= ~tout_pin;
    end
  end

  assign rst_req  = (rcnt_q != '0);
  assign rst_warm = cfg_q.warm;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_PRE1: rd_data = 32'(pre1_q);
      A_PRE2: rd_data = 32'(pre2_q);
      A_KEY:  rd_data = {22'b0, tout_flag, 9'b0};
      A_CFG:  rd_data = {26'b0, cfg_q, 2'b0};
      A_CNT:  rd_data = 32'(cnt);
      A_LOCK: rd_data = {30'b0, en_q, lock_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int PRE_W = 20
)(
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             lock_q,
  input logic [3:0]       cfg_q,
  input logic             tout_flag,
  input logic             rst_req,
  input logic [PRE_W-1:0] pre1_q,
  input logic             armed
);
  assert_key_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pre1_q) |-> $past(armed));

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  assert_lock_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && en_q) |=> en_q);

  assert_lock_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(cfg_q));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !$rose(tout_flag));

  assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |=> rst_req);

  assert_rst_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(en_q));
endmodule

bind wdt_keyed wdt_keyed_chk #(.PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .lock_q(lock_q), .cfg_q(cfg_q),
  .tout_flag(tout_flag), .rst_req(rst_req), .pre1_q(pre1_q), .armed(armed)
);

// File: tb/tb_wdt_keyed.sv
`timescale 1ns/1ps
module tb_wdt_keyed;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [4:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        tout_flag, rst_req, rst_warm, tout_pin;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  wdt_keyed #(.PRE_W(20), .FRAC(2)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tout_flag(tout_flag), .rst_req(rst_req),
    .rst_warm(rst_warm), .tout_pin(tout_pin)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic key();
    wr(5'h0C, 32'h80); wr(5'h0C, 32'h86);
  endtask

  task automatic kwr(input logic [4:0] a, input logic [31:0] d);
    key(); wr(a, d);
  endtask

  task automatic until_flag(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); @(negedge clk); n++;
      if (tout_flag) break;
    end
  endtask

  task automatic until_rst(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); @(negedge clk); n++;
      if (rst_req) break;
    end
  endtask

  task automatic stop_clear();
    wr(5'h18, 0); kwr(5'h0D, 32'h02);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(!rst_req && !tout_flag && !tout_pin && !rst_warm, "R11 outputs", rst_req, 0);
    rd(5'h18, d); chk(d == 0, "R11 lock reg", d, 0);
    rd(5'h00, d); chk(d == 0, "R11 pre1", d, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d; int n; bit ok;
    kwr(5'h00, 5); kwr(5'h04, 3); wr(5'h10, 32'h10);
    rd(5'h00, d); chk(d == 5, "R1 keyed pre1", d, 5);
    wr(5'h18, 32'h02);
    until_flag(n); chk(n == 6, "R6 stage1 length", n, 6);
    until_rst(n);  chk(n == 4, "R8 stage2 length", n, 4);
    chk(!rst_warm, "R8 cold", rst_warm, 0);
    chk(tout_pin, "R9 pin toggled", tout_pin, 1);
    ok = 1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); ok &= rst_req; end
    @(negedge clk); ok &= !rst_req;
    chk(ok, "R8 pulse 4 clocks", ok, 1);
    stop_clear();
    rd(5'h0C, d); chk(d[9] == 0, "R5 flag cleared", d[9], 0);
  endtask

  task automatic t_once();
    logic [31:0] d;
    kwr(5'h00, 7); wr(5'h00, 9);
    rd(5'h00, d); chk(d == 7, "R2 second write dropped", d, 7);
  endtask

  task automatic t_broken();
    logic [31:0] d;
    wr(5'h0C, 32'h80); wr(5'h10, 32'h10); wr(5'h0C, 32'h86); wr(5'h00, 11);
    rd(5'h00, d); chk(d == 7, "R3 other write between", d, 7);
    wr(5'h0C, 32'h80); wr(5'h0C, 32'h55); wr(5'h0C, 32'h86); wr(5'h00, 12);
    rd(5'h00, d); chk(d == 7, "R3 wrong byte", d, 7);
    key(); wr(5'h10, 32'h10); wr(5'h00, 13);
    rd(5'h00, d); chk(d == 7, "R3 write after key", d, 7);
  endtask

  task automatic t_refresh();
    int n;
    kwr(5'h00, 20); wr(5'h18, 32'h02);
    repeat (5) @(posedge clk);
    kwr(5'h0D, 32'h01);
    chk(!tout_flag, "R4 no early flag", tout_flag, 0);
    until_flag(n); chk(n == 21, "R4 refresh restarts", n, 21);
    stop_clear();
  endtask

  task automatic t_presc();
    int n;
    wr(5'h10, 32'h14); kwr(5'h00, 2); wr(5'h18, 32'h02);
    until_flag(n); chk(n == 12, "R7 prescaled length", n, 12);
    stop_clear();
  endtask

  task automatic t_modes();
    int n; bit seen;
    logic p0;
    wr(5'h10, 32'h38); kwr(5'h00, 1); kwr(5'h04, 2);
    p0 = tout_pin;
    wr(5'h18, 32'h02);
    until_flag(n); chk(n == 2, "R6 short stage1", n, 2);
    until_rst(n);  chk(n == 3, "R8 short stage2", n, 3);
    chk(rst_warm, "R8 warm", rst_warm, 1);
    chk(tout_pin == p0, "R9 toggle disabled", tout_pin, p0);
    stop_clear();
    wr(5'h10, 32'h08); wr(5'h18, 32'h02);
    seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); seen |= rst_req; end
    chk(!seen, "R8 reset disabled", seen, 0);
    stop_clear();
  endtask

  task automatic t_idle();
    logic [31:0] d; bit seen;
    kwr(5'h00, 1); wr(5'h10, 32'h10);
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= tout_flag; end
    chk(!seen, "R11 no timeout when off", seen, 0);
    rd(5'h14, d); chk(d == 1, "R11 counter held", d, 1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(5'h18, 32'h03); wr(5'h18, 32'h00);
    rd(5'h18, d); chk(d == 3, "R10 enable and lock stay", d, 3);
    wr(5'h10, 32'h20);
    rd(5'h10, d); chk(d == 32'h10, "R10 config frozen", d, 32'h10);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(5'h18, d); chk(d == 0, "R10 reset clears lock", d, 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_basic(); t_once(); t_broken(); t_refresh();
    t_presc(); t_modes(); t_idle(); t_lock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule